// File: doc/BRIEF.md
# SDRAM Command Spacing Gate

This block sits between an SDRAM command sequencer and the memory command pins. The sequencer offers one command at a time over a valid/ready handshake. The block holds that command back until every minimum spacing that applies to it has passed since the earlier commands. It then accepts the command and drives a one-cycle issue strobe, with the command code, toward the pins on the following cycle.

Two timing codes set all of the spacings. A 4-bit activate-to-precharge code and a 3-bit precharge-recovery code come from a global control register. The row-cycle, refresh-cycle and self-refresh-exit spacings are not programmed separately. Each of them is the sum of the two codes. Every spacing is tracked by its own down-counter. A counter is loaded when the command that starts that spacing is accepted. A command is released only when all counters that gate it have run out.

Top module: `sdram_cmd_spacer`

## Requirements
- R1: Reset clears all spacing state. During reset `pin_issue` is 0. After reset, any command is accepted in the first cycle it is offered.
- R2: Command codes: 0 is bank activate, 1 is read/write, 2 is precharge, 3 is auto-refresh, 4 is self-refresh entry, 5 is self-refresh exit. With `cfg_ras` code N in 1..15, a precharge is accepted no earlier than N cycles after the accept cycle of a bank activate.
- R3: With `cfg_rp` code M in 1..7, a bank activate is accepted no earlier than M cycles after a precharge.
- R4: The same M-cycle spacing applies from a precharge to a following auto-refresh and to a following self-refresh entry.
- R5: A code of 0 in either field adds no spacing from that field. A gated command may then follow one cycle after the command it depends on.
- R6: A bank activate follows an earlier bank activate by at least N+M cycles.
- R7: After an auto-refresh, no command of any kind is accepted until N+M cycles have passed.
- R8: After a self-refresh exit, no command of any kind is accepted until N+M cycles have passed.
- R9: A change to either code while any spacing counter is running has no effect until all counters are idle.
- R10: A command that is held back keeps `req_ready` low and is never dropped. `pin_issue` pulses for exactly one cycle, in the cycle after each accept, with `pin_cmd` equal to the accepted code.
- R11: A read/write is not delayed by the activate-to-precharge, precharge-recovery or row-cycle spacings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ras | input | 4 | Activate-to-precharge spacing code |
| cfg_rp | input | 3 | Precharge-recovery spacing code |
| req_valid | input | 1 | Sequencer offers a command |
| req_cmd | input | 3 | Offered command code |
| req_ready | output | 1 | Offered command may be accepted this cycle |
| pin_issue | output | 1 | One-cycle strobe: command goes to the pins |
| pin_cmd | output | 3 | Command code driven with the strobe |

## Verification
The bench measures the distance in cycles between the accepts of two back-to-back commands. It covers both extremes of each code and the zero codes. A design off by one in its counter load shows a gap one cycle too long or too short. A design that mixes up which counters gate which command lets a precharge through early, or needlessly stalls a read/write. One test changes the codes while a counter is running, which exposes a design that applies new codes immediately. Another asserts reset in the middle of a spacing, which exposes counters that survive reset. The stalled cycles are also checked for stray strobes.

// File: rtl/sdcs_pkg.sv
package sdcs_pkg;

    localparam int RAS_W = 4;
    localparam int RP_W  = 3;
    localparam int CNT_W = RAS_W + 1;

    typedef enum logic [2:0] {
        CMD_ACT  = 3'd0,
        CMD_RW   = 3'd1,
        CMD_PRE  = 3'd2,
        CMD_AREF = 3'd3,
        CMD_SRE  = 3'd4,
        CMD_SRX  = 3'd5
    } cmd_e;

    // spacing counters, one per enforced window
    typedef enum int {
        SP_RAS = 0,   // activate -> precharge
        SP_RP  = 1,   // precharge -> activate / refresh / self-refresh entry
        SP_RC  = 2,   // activate -> activate
        SP_RFC = 3,   // auto-refresh -> anything
        SP_XSR = 4    // self-refresh exit -> anything
    } span_e;

    localparam int NUM_SP = 5;

    typedef logic [NUM_SP-1:0] span_vec_t;

    // counters that must be idle before a command may pass
    function automatic span_vec_t gating_of(input cmd_e c);
        span_vec_t v;
        v = '0;
        v[SP_RFC] = 1'b1;
        v[SP_XSR] = 1'b1;
        case (c)
            CMD_ACT: begin v[SP_RP] = 1'b1; v[SP_RC] = 1'b1; end
            CMD_PRE: v[SP_RAS] = 1'b1;
            CMD_AREF, CMD_SRE: v[SP_RP] = 1'b1;
            default: ;
        endcase
        return v;
    endfunction

    // counters a command starts when accepted
    function automatic span_vec_t starts_of(input cmd_e c);
        span_vec_t v;
        v = '0;
        case (c)
            CMD_ACT:  begin v[SP_RAS] = 1'b1; v[SP_RC] = 1'b1; end
            CMD_PRE:  v[SP_RP]  = 1'b1;
            CMD_AREF: v[SP_RFC] = 1'b1;
            CMD_SRX:  v[SP_XSR] = 1'b1;
            default: ;
        endcase
        return v;
    endfunction

    // a span of S cycles blocks the next S-1 cycles after the accept
    function automatic logic [CNT_W-1:0] load_of(input logic [CNT_W-1:0] span);
        return (span == '0) ? '0 : span - 1'b1;
    endfunction

endpackage

// File: rtl/sdcs_down_counter.sv
module sdcs_down_counter #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         idle
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign idle = (cnt == '0);

    // a running window never finishes early (R10)
    assert_window_runs_R10: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt > 1) |=> !idle);
endmodule

// File: rtl/sdcs_cfg_hold.sv
module sdcs_cfg_hold #(
    parameter int RAS_W = 4,
    parameter int RP_W  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             busy,
    input  logic [RAS_W-1:0] ras_in,
    input  logic [RP_W-1:0]  rp_in,
    output logic [RAS_W-1:0] ras_eff,
    output logic [RP_W-1:0]  rp_eff
);
    logic [RAS_W-1:0] ras_q;
    logic [RP_W-1:0]  rp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ras_q <= '0;
            rp_q  <= '0;
        end else if (!busy) begin
            ras_q <= ras_in;
            rp_q  <= rp_in;
        end
    end

    assign ras_eff = busy ? ras_q : ras_in;
    assign rp_eff  = busy ? rp_q  : rp_in;

    // codes seen by the counters stay frozen while a window runs (R9)
    assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !$past(rst)) |-> (ras_eff == $past(ras_eff) && rp_eff == $past(rp_eff)));
endmodule

// File: rtl/sdcs_release_gate.sv
module sdcs_release_gate
    import sdcs_pkg::*;
(
    input  logic      valid,
    input  cmd_e      cmd,
    input  span_vec_t idle,
    output logic      ready,
    output span_vec_t start,
    output logic      busy
);
    span_vec_t blocking;

    always_comb begin
        blocking = gating_of(cmd) & ~idle;
        ready    = (blocking == '0);
        start    = (valid && ready) ? starts_of(cmd) : '0;
        busy     = (idle != '1);
    end
endmodule

// File: rtl/sdram_cmd_spacer.sv
module sdram_cmd_spacer
    import sdcs_pkg::*;
#(
    parameter int RAS_BITS = RAS_W,
    parameter int RP_BITS  = RP_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [RAS_BITS-1:0] cfg_ras,
    input  logic [RP_BITS-1:0]  cfg_rp,
    input  logic                req_valid,
    input  logic [2:0]          req_cmd,
    output logic                req_ready,
    output logic                pin_issue,
    output logic [2:0]          pin_cmd
);
    localparam int SUM_W = ((RAS_BITS > RP_BITS) ? RAS_BITS : RP_BITS) + 1;

    logic [RAS_BITS-1:0] ras_eff;
    logic [RP_BITS-1:0]  rp_eff;
    logic [SUM_W-1:0]    ras_ext, rp_ext, sum_span;
    logic                busy, accept;
    cmd_e                cmd;
    span_vec_t           idle, start;
    logic [SUM_W-1:0]    load_val [NUM_SP];

    assign cmd = cmd_e'(req_cmd);

    sdcs_cfg_hold #(.RAS_W(RAS_BITS), .RP_W(RP_BITS)) u_cfg (
        .clk(clk), .rst(rst), .busy(busy),
        .ras_in(cfg_ras), .rp_in(cfg_rp),
        .ras_eff(ras_eff), .rp_eff(rp_eff)
    );

    assign ras_ext  = SUM_W'(ras_eff);
    assign rp_ext   = SUM_W'(rp_eff);
    assign sum_span = ras_ext + rp_ext;

    sdcs_release_gate u_gate (
        .valid(req_valid), .cmd(cmd), .idle(idle),
        .ready(req_ready), .start(start), .busy(busy)
    );

    assign accept = req_valid && req_ready;

    always_comb begin
        load_val[SP_RAS] = load_of(CNT_W'(ras_ext));
        load_val[SP_RP]  = load_of(CNT_W'(rp_ext));
        load_val[SP_RC]  = load_of(CNT_W'(sum_span));
        load_val[SP_RFC] = load_of(CNT_W'(sum_span));
        load_val[SP_XSR] = load_of(CNT_W'(sum_span));
    end

    for (genvar g = 0; g < NUM_SP; g++) begin : g_span
        sdcs_down_counter #(.W(SUM_W)) u_cnt (
            .clk(clk), .rst(rst), .load(start[g]),
            .load_val(load_val[g]), .idle(idle[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_issue <= 1'b0;
            pin_cmd   <= 3'd0;
        end else begin
            pin_issue <= accept;
            if (accept) pin_cmd <= req_cmd;
        end
    end

    // precharge never lands in the cycle after an activate with a 2+ code
    assert_ras_gap_R2: assert property (@(posedge clk) disable iff (rst)
        (accept && cmd == CMD_ACT && ras_eff >= 2) |=> !(accept && cmd == CMD_PRE));

    assert_rp_gap_R3: assert property (@(posedge clk) disable iff (rst)
        (accept && cmd == CMD_PRE && rp_eff >= 2) |=>
        !(accept && (cmd == CMD_ACT || cmd == CMD_AREF || cmd == CMD_SRE)));

    assert_rc_gap_R6: assert property (@(posedge clk) disable iff (rst)
        (accept && cmd == CMD_ACT && sum_span >= 2) |=> !(accept && cmd == CMD_ACT));

    assert_rfc_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (accept && cmd == CMD_AREF && sum_span >= 2) |=> !accept);

    assert_xsr_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (accept && cmd == CMD_SRX && sum_span >= 2) |=> !accept);

    assert_strobe_R10: assert property (@(posedge clk) disable iff (rst)
        pin_issue |-> $past(req_valid));
endmodule

// File: tb/test_sdram_cmd_spacer.sv
module test_sdram_cmd_spacer;
    localparam logic [2:0] ACT = 3'd0, RW = 3'd1, PRE = 3'd2,
                           AREF = 3'd3, SRE = 3'd4, SRX = 3'd5;

    // {ras code, rp code, first cmd, second cmd, expected accept gap, req id}
    localparam int NV = 17;
    localparam logic [21:0] VEC [NV] = '{
        {4'd5,  3'd3, ACT,  PRE,  5'd5,  4'd2},   // R2
        {4'd15, 3'd7, ACT,  PRE,  5'd15, 4'd2},   // R2
        {4'd1,  3'd1, ACT,  PRE,  5'd1,  4'd2},   // R2
        {4'd4,  3'd6, PRE,  ACT,  5'd6,  4'd3},   // R3
        {4'd4,  3'd7, PRE,  AREF, 5'd7,  4'd4},   // R4
        {4'd4,  3'd3, PRE,  SRE,  5'd3,  4'd4},   // R4
        {4'd0,  3'd0, ACT,  PRE,  5'd1,  4'd5},   // R5
        {4'd0,  3'd0, PRE,  ACT,  5'd1,  4'd5},   // R5
        {4'd5,  3'd0, PRE,  ACT,  5'd1,  4'd5},   // R5
        {4'd6,  3'd3, ACT,  ACT,  5'd9,  4'd6},   // R6
        {4'd0,  3'd5, ACT,  ACT,  5'd5,  4'd6},   // R6
        {4'd2,  3'd3, AREF, RW,   5'd5,  4'd7},   // R7
        {4'd15, 3'd7, AREF, ACT,  5'd22, 4'd7},   // R7
        {4'd3,  3'd4, SRX,  RW,   5'd7,  4'd8},   // R8
        {4'd0,  3'd0, SRX,  ACT,  5'd1,  4'd8},   // R8
        {4'd7,  3'd2, ACT,  RW,   5'd1,  4'd11},  // R11
        {4'd3,  3'd5, PRE,  RW,   5'd1,  4'd11}   // R11
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] cfg_ras = '0;
    logic [2:0] cfg_rp = '0;
    logic       req_valid = 1'b0;
    logic [2:0] req_cmd = '0;
    logic       req_ready, pin_issue;
    logic [2:0] pin_cmd;
    int         cyc = 0;
    int         checks = 0, failures = 0;
    bit         done = 1'b0;

    sdram_cmd_spacer i_sdram_cmd_spacer (
        .clk(clk), .rst(rst), .cfg_ras(cfg_ras), .cfg_rp(cfg_rp),
        .req_valid(req_valid), .req_cmd(req_cmd), .req_ready(req_ready),
        .pin_issue(pin_issue), .pin_cmd(pin_cmd)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input int rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL R%0d actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // called at a falling edge; returns the cycle stamp of the accept
    task automatic send(input logic [2:0] c, input int rq, output int hs);
        int waits = 0;
        req_valid = 1'b1;
        req_cmd   = c;
        #1;
        while (!req_ready && waits < 100) begin
            if (waits > 0) chk(pin_issue == 1'b0, 10, pin_issue, 0);   // R10 no strobe while held
            @(negedge clk); #1;
            waits++;
        end
        @(posedge clk);
        @(negedge clk);
        hs = cyc;
        chk(pin_issue == 1'b1 && pin_cmd == c, 10, {pin_issue, pin_cmd}, {1'b1, c}); // R10
        req_valid = 1'b0;
        if (rq < 0) hs = -1;
    endtask

    task automatic idle_gap(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int ha, hb;
        repeat (3) begin
            @(negedge clk);
            chk(pin_issue == 1'b0, 1, pin_issue, 0);   // R1 quiet during reset
        end
        rst = 1'b0;
        @(negedge clk);
        req_cmd = PRE; #1;
        chk(req_ready == 1'b1, 1, req_ready, 1);       // R1 accept at once

        for (int i = 0; i < NV; i++) begin
            idle_gap(30);
            cfg_ras = VEC[i][21:18];
            cfg_rp  = VEC[i][17:15];
            send(VEC[i][14:12], VEC[i][3:0], ha);
            send(VEC[i][11:9],  VEC[i][3:0], hb);
            chk(hb - ha == int'(VEC[i][8:4]), VEC[i][3:0], hb - ha, VEC[i][8:4]);
            @(negedge clk);
            chk(pin_issue == 1'b0, 10, pin_issue, 0);  // R10 single pulse
        end

        // R9: code change during a running window is deferred
        idle_gap(30);
        cfg_ras = 4'd10; cfg_rp = 3'd2;
        send(ACT, 9, ha);
        cfg_ras = 4'd1;
        send(PRE, 9, hb);
        chk(hb - ha == 10, 9, hb - ha, 10);
        idle_gap(30);
        send(ACT, 9, ha);
        send(PRE, 9, hb);
        chk(hb - ha == 1, 9, hb - ha, 1);

        // R1: reset in the middle of a window clears it
        idle_gap(30);
        cfg_ras = 4'd15; cfg_rp = 3'd7;
        send(ACT, 1, ha);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        req_cmd = ACT; #1;
        chk(req_ready == 1'b1, 1, req_ready, 1);
        send(PRE, 1, hb);
        chk(hb - ha == 2, 1, hb - ha, 2);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R10 watchdog actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule